// File: doc/BRIEF.md
# Space-Vector Gating Time Calculator

This block turns three signed phase voltage references into per-phase gating times for a three-phase carrier-based space-vector PWM. It runs once per sampling interval. Each reference is scaled by the sampling period over the DC-link voltage to give an imaginary switching time. The DC-link division is done by multiplying with a precomputed reciprocal. The block then finds the largest and smallest of the three times. It adds one common offset to all three phases, so that the active-vector interval sits in the middle of the period and the zero-vector time is split evenly on either side. The results are clamped to the period and presented with a one-cycle valid pulse.

A small sequencer with three states drives the work:
- `ST_IDLE` waits for `sample_stb`. On the strobe it latches the three imaginary times and the period, then moves to `ST_SORT` (transition "accept").
- `ST_SORT` latches the maximum and minimum and always moves to `ST_PLACE` (transition "sorted").
- `ST_PLACE` latches the shifted, clamped gating times, raises the valid flag and always returns to `ST_IDLE` (transition "done").

Strobes that arrive outside `ST_IDLE` are dropped. The next accepted strobe can therefore come no sooner than three cycles after the previous one. All times are signed 16-bit timer ticks.

Top module: `svt_timing_unit`

## Requirements
- R1: While `rst_n` is low, `gate_vld` is 0 and `gate_a`, `gate_b` and `gate_c` are all 0.
- R2: The imaginary time of each phase is floor(v_ref × t_samp × vdc_recip / 2^16), saturated to the range −32768..32767. Here `vdc_recip` is 2^16 divided by the DC-link voltage, in the same units as the references.
- R3: With t_max and t_min the largest and smallest imaginary times and teff = t_max − t_min, the common offset is floor((t_samp − teff)/2) − t_min. When no phase is clamped, the smallest gating time therefore equals floor((t_samp − teff)/2).
- R4: Every phase gets the same offset. Before clamping, gating time = imaginary time + offset, so the differences between phases equal the differences between their imaginary times.
- R5: Each gating time is clamped to the range 0..t_samp, using the period latched with the strobe.
- R6: A strobe accepted at a rising edge gives results, with `gate_vld` high, right after the third rising edge counted from and including that one. `gate_vld` stays high for exactly one cycle.
- R7: A strobe that arrives in the two cycles after an accepted strobe is ignored. It produces no result and does not change the pending one.
- R8: `gate_a`, `gate_b` and `gate_c` keep their values in every cycle except the one in which `gate_vld` rises.
- R9: Three equal references give three gating times equal to floor(t_samp/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_stb | input | 1 | Start of a sampling interval |
| v_ref_a | input | 16 | Phase A voltage reference, signed |
| v_ref_b | input | 16 | Phase B voltage reference, signed |
| v_ref_c | input | 16 | Phase C voltage reference, signed |
| t_samp | input | 16 | Sampling period in ticks, 1..32767 |
| vdc_recip | input | 16 | 2^16 / DC-link voltage, unsigned |
| gate_a | output | 16 | Phase A gating time, signed ticks |
| gate_b | output | 16 | Phase B gating time, signed ticks |
| gate_c | output | 16 | Phase C gating time, signed ticks |
| gate_vld | output | 1 | One-cycle result strobe |

## Verification
The assertions check four properties on every cycle: the valid pulse lasts one cycle and trails an input strobe by three edges, every presented gating time lies inside the latched period, the outputs do not move outside a result cycle, and the sorter's extremes bound all three imaginary times. Other behaviour shows up only through the bench's scenarios compared against its cycle model. This covers the arithmetic of scaling and centring, the flooring of negative values, the clamping when the line-to-line spread exceeds the period, the saturation of very large products, and the dropping of strobes while a result is in flight.

// File: rtl/svt_pkg.sv
package svt_pkg;
    localparam int NPH = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SORT  = 2'd1,
        ST_PLACE = 2'd2
    } svt_state_e;
endpackage

// File: rtl/svt_scale.sv
module svt_scale #(
    parameter int DW    = 16,
    parameter int KW    = 16,
    parameter int KFRAC = 16
) (
    input  logic signed [DW-1:0] v_ref,
    input  logic        [DW-1:0] t_samp,
    input  logic        [KW-1:0] k_recip,
    output logic signed [DW-1:0] t_im
);
    localparam int PW = DW + DW + KW + 2;
    localparam logic signed [PW-1:0] T_HI = PW'((longint'(1) <<< (DW - 1)) - 1);
    localparam logic signed [PW-1:0] T_LO = -T_HI - PW'(1);

    logic signed [PW-1:0] v_x, t_x, k_x, prod, scaled;

    assign v_x    = PW'(v_ref);
    assign t_x    = PW'({1'b0, t_samp});
    assign k_x    = PW'({1'b0, k_recip});
    assign prod   = v_x * t_x * k_x;
    assign scaled = prod >>> KFRAC;

    always_comb begin
        if (scaled > T_HI)
            t_im = T_HI[DW-1:0];
        else if (scaled < T_LO)
            t_im = T_LO[DW-1:0];
        else
            t_im = scaled[DW-1:0];
    end
endmodule

// File: rtl/svt_sort.sv
module svt_sort #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] t_p0,
    input  logic signed [DW-1:0] t_p1,
    input  logic signed [DW-1:0] t_p2,
    output logic signed [DW-1:0] t_max,
    output logic signed [DW-1:0] t_min
);
    logic signed [DW-1:0] hi01, lo01;

    always_comb begin
        hi01  = (t_p0 > t_p1) ? t_p0 : t_p1;
        lo01  = (t_p0 < t_p1) ? t_p0 : t_p1;
        t_max = (hi01 > t_p2) ? hi01 : t_p2;
        t_min = (lo01 < t_p2) ? lo01 : t_p2;
    end
endmodule

// File: rtl/svt_centre.sv
module svt_centre #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] t_max,
    input  logic signed [DW-1:0] t_min,
    input  logic        [DW-1:0] t_samp,
    output logic signed [DW+3:0] t_ofs
);
    localparam int XW = DW + 4;

    logic signed [XW-1:0] mx, mn, per, teff, t_zero_half;

    assign mx          = XW'(t_max);
    assign mn          = XW'(t_min);
    assign per         = XW'({1'b0, t_samp});
    assign teff        = mx - mn;
    assign t_zero_half = (per - teff) >>> 1;
    assign t_ofs       = t_zero_half - mn;
endmodule

// File: rtl/svt_gate.sv
module svt_gate #(
    parameter int DW = 16
) (
    input  logic signed [DW-1:0] t_im,
    input  logic signed [DW+3:0] t_ofs,
    input  logic        [DW-1:0] t_samp,
    output logic signed [DW-1:0] t_gate
);
    localparam int XW = DW + 4;

    logic signed [XW-1:0] shifted, per;

    assign shifted = XW'(t_im) + t_ofs;
    assign per     = XW'({1'b0, t_samp});

    always_comb begin
        if (shifted < 0)
            t_gate = '0;
        else if (shifted > per)
            t_gate = $signed(t_samp);
        else
            t_gate = shifted[DW-1:0];
    end
endmodule

// File: rtl/svt_timing_unit.sv
module svt_timing_unit
    import svt_pkg::*;
#(
    parameter int DW    = 16,
    parameter int KW    = 16,
    parameter int KFRAC = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_stb,
    input  logic signed [DW-1:0] v_ref_a,
    input  logic signed [DW-1:0] v_ref_b,
    input  logic signed [DW-1:0] v_ref_c,
    input  logic        [DW-1:0] t_samp,
    input  logic        [KW-1:0] vdc_recip,
    output logic signed [DW-1:0] gate_a,
    output logic signed [DW-1:0] gate_b,
    output logic signed [DW-1:0] gate_c,
    output logic                 gate_vld
);
    svt_state_e st_q, st_d;

    logic signed [DW-1:0] v_in    [NPH];
    logic signed [DW-1:0] t_im_c  [NPH];
    logic signed [DW-1:0] t_im_q  [NPH];
    logic signed [DW-1:0] gate_c_w [NPH];
    logic        [DW-1:0] t_samp_q;
    logic signed [DW-1:0] t_max_c, t_min_c, t_max_q, t_min_q;
    logic signed [DW+3:0] t_ofs_c;

    assign v_in[0] = v_ref_a;
    assign v_in[1] = v_ref_b;
    assign v_in[2] = v_ref_c;

    // Per-phase scaling and per-phase shift/clamp
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        svt_scale #(.DW(DW), .KW(KW), .KFRAC(KFRAC)) u_scale (
            .v_ref   (v_in[p]),
            .t_samp  (t_samp),
            .k_recip (vdc_recip),
            .t_im    (t_im_c[p])
        );

        svt_gate #(.DW(DW)) u_gate (
            .t_im   (t_im_q[p]),
            .t_ofs  (t_ofs_c),
            .t_samp (t_samp_q),
            .t_gate (gate_c_w[p])
        );
    end

    svt_sort #(.DW(DW)) u_sort (
        .t_p0  (t_im_q[0]),
        .t_p1  (t_im_q[1]),
        .t_p2  (t_im_q[2]),
        .t_max (t_max_c),
        .t_min (t_min_c)
    );

    svt_centre #(.DW(DW)) u_centre (
        .t_max  (t_max_q),
        .t_min  (t_min_q),
        .t_samp (t_samp_q),
        .t_ofs  (t_ofs_c)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (sample_stb) st_d = ST_SORT;
            ST_SORT:  st_d = ST_PLACE;
            ST_PLACE: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPH; p++) t_im_q[p] <= '0;
            t_samp_q <= '0;
            t_max_q  <= '0;
            t_min_q  <= '0;
            gate_a   <= '0;
            gate_b   <= '0;
            gate_c   <= '0;
            gate_vld <= 1'b0;
        end else begin
            gate_vld <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (sample_stb) begin
                        for (int p = 0; p < NPH; p++) t_im_q[p] <= t_im_c[p];
                        t_samp_q <= t_samp;
                    end
                end
                ST_SORT: begin
                    t_max_q <= t_max_c;
                    t_min_q <= t_min_c;
                end
                ST_PLACE: begin
                    gate_a   <= gate_c_w[0];
                    gate_b   <= gate_c_w[1];
                    gate_c   <= gate_c_w[2];
                    gate_vld <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/svt_timing_chk.sv
module svt_timing_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_stb,
    input logic                 gate_vld,
    input logic signed [DW-1:0] gate_a,
    input logic signed [DW-1:0] gate_b,
    input logic signed [DW-1:0] gate_c,
    input logic        [DW-1:0] t_samp_q,
    input logic signed [DW-1:0] t_im0,
    input logic signed [DW-1:0] t_im1,
    input logic signed [DW-1:0] t_im2,
    input logic signed [DW-1:0] t_max_c,
    input logic signed [DW-1:0] t_min_c
);
    logic signed [DW:0] per_x;
    assign per_x = {1'b0, t_samp_q};

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gate_vld |=> !gate_vld); // R6

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        gate_vld |-> $past(sample_stb, 3)); // R6

    AST_GATE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        gate_vld |-> (gate_a >= 0 && gate_b >= 0 && gate_c >= 0 &&
                      (DW+1)'(gate_a) <= per_x && (DW+1)'(gate_b) <= per_x &&
                      (DW+1)'(gate_c) <= per_x)); // R5

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_vld |-> ($stable(gate_a) && $stable(gate_b) && $stable(gate_c))); // R8

    AST_SORT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (t_max_c >= t_im0 && t_max_c >= t_im1 && t_max_c >= t_im2 &&
         t_min_c <= t_im0 && t_min_c <= t_im1 && t_min_c <= t_im2)); // R3
endmodule

bind svt_timing_unit svt_timing_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .gate_vld   (gate_vld),
    .gate_a     (gate_a),
    .gate_b     (gate_b),
    .gate_c     (gate_c),
    .t_samp_q   (t_samp_q),
    .t_im0      (t_im_q[0]),
    .t_im1      (t_im_q[1]),
    .t_im2      (t_im_q[2]),
    .t_max_c    (t_max_c),
    .t_min_c    (t_min_c)
);

// File: tb/svt_timing_unit_bench.sv
`timescale 1ns/1ps
module svt_timing_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic signed [15:0] va = '0, vb = '0, vc = '0;
    logic [15:0] ts = 16'd1000, kr = 16'd164;
    logic signed [15:0] gate_a, gate_b, gate_c;
    logic gate_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    svt_timing_unit u_svt_timing_unit (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .v_ref_a(va), .v_ref_b(vb), .v_ref_c(vc),
        .t_samp(ts), .vdc_recip(kr),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c),
        .gate_vld(gate_vld)
    );

    // ---------------- reference model ----------------
    typedef struct { bit vld; int g0; int g1; int g2; } res_t;
    res_t mq[$];
    res_t m_new, m_old;
    int  m_busy = 0;
    bit  exp_vld = 1'b0;
    int  exp_a = 0, exp_b = 0, exp_c = 0;

    function automatic int imag_time(int v, int t, int k);
        longint p;
        p = longint'(v) * longint'(t) * longint'(k);
        p = p >>> 16;
        if (p > 32767) return 32767;
        if (p < -32768) return -32768;
        return int'(p);
    endfunction

    function automatic int clamp_gate(int x, int t);
        if (x < 0) return 0;
        if (x > t) return t;
        return x;
    endfunction

    task automatic model_result(input int v0, input int v1, input int v2,
                                input int t, input int k,
                                output int g0, output int g1, output int g2);
        int i0, i1, i2, mx, mn, ofs;
        i0 = imag_time(v0, t, k);
        i1 = imag_time(v1, t, k);
        i2 = imag_time(v2, t, k);
        mx = i0; if (i1 > mx) mx = i1; if (i2 > mx) mx = i2;
        mn = i0; if (i1 < mn) mn = i1; if (i2 < mn) mn = i2;
        ofs = ((t - (mx - mn)) >>> 1) - mn;
        g0 = clamp_gate(i0 + ofs, t);
        g1 = clamp_gate(i1 + ofs, t);
        g2 = clamp_gate(i2 + ofs, t);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_busy  = 0;
            exp_vld = 1'b0;
            exp_a = 0; exp_b = 0; exp_c = 0;
        end else begin
            m_new.vld = 1'b0; m_new.g0 = 0; m_new.g1 = 0; m_new.g2 = 0;
            if (m_busy > 0) begin
                m_busy = m_busy - 1;
            end else if (sample_stb) begin
                m_new.vld = 1'b1;
                model_result(int'(va), int'(vb), int'(vc), int'(ts), int'(kr),
                             m_new.g0, m_new.g1, m_new.g2);
                m_busy = 2;
            end
            mq.push_back(m_new);
            exp_vld = 1'b0;
            if (mq.size() >= 3) begin
                m_old = mq.pop_front();
                exp_vld = m_old.vld;
                if (m_old.vld) begin
                    exp_a = m_old.g0; exp_b = m_old.g1; exp_c = m_old.g2;
                end
            end
        end
    end

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (gate_vld !== exp_vld) begin
                n_bad++;
                $display("FAIL R6 R7 valid: actual %0b expected %0b at %0t", gate_vld, exp_vld, $time);
            end
            n_chk++;
            if (int'(gate_a) != exp_a || int'(gate_b) != exp_b || int'(gate_c) != exp_c) begin
                n_bad++;
                $display("FAIL R2 R3 R4 R5 R8 gates: actual %0d %0d %0d expected %0d %0d %0d at %0t",
                         gate_a, gate_b, gate_c, exp_a, exp_b, exp_c, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input int a, input int b, input int c);
        @(negedge clk);
        va = 16'(a); vb = 16'(b); vc = 16'(c);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic wait_result;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    // ---------------- stimulus ----------------
    initial begin
        int pulses;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_eq("R1 vld", int'(gate_vld), 0);
        check_eq("R1 gate_a", int'(gate_a), 0);
        check_eq("R1 gate_b", int'(gate_b), 0);
        check_eq("R1 gate_c", int'(gate_c), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: equal references centre at half period
        ts = 16'd1000; kr = 16'd164;
        send(0, 0, 0);
        wait_result();
        check_eq("R9 vld", int'(gate_vld), 1);
        check_eq("R9 gate_a", int'(gate_a), 500);
        check_eq("R9 gate_b", int'(gate_b), 500);
        check_eq("R9 gate_c", int'(gate_c), 500);

        // R3 / R4: centring with a negative floored time
        send(100, -50, -50);
        wait_result();
        check_eq("R3 min gate", int'(gate_b), 312);
        check_eq("R4 spread a-b", int'(gate_a) - int'(gate_b), 376);
        check_eq("R4 equal b c", int'(gate_c), int'(gate_b));

        // R5: spread wider than the period clamps both ends
        send(400, -400, 0);
        wait_result();
        check_eq("R5 gate_a high clamp", int'(gate_a), 1000);
        check_eq("R5 gate_b low clamp", int'(gate_b), 0);
        check_eq("R5 gate_c", int'(gate_c), 500);

        // R2: saturated imaginary times
        ts = 16'd30000; kr = 16'd65535;
        send(30000, -30000, 0);
        wait_result();
        check_eq("R2 saturated centre", int'(gate_c), 15000);
        check_eq("R2 gate_a", int'(gate_a), 30000);
        repeat (3) @(negedge clk);

        // R7: second strobe one cycle later is dropped
        ts = 16'd1000; kr = 16'd164;
        pulses = 0;
        @(negedge clk);
        va = 16'sd120; vb = -16'sd60; vc = -16'sd60; sample_stb = 1'b1;
        @(negedge clk);
        va = -16'sd300; vb = 16'sd300; vc = 16'sd0;
        @(negedge clk);
        sample_stb = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (gate_vld) pulses++;
            @(negedge clk);
        end
        check_eq("R7 one result from busy strobes", pulses, 1);

        // R6 / R7: strobe held high nine cycles gives three results
        pulses = 0;
        sample_stb = 1'b1;
        for (int i = 0; i < 9; i++) begin
            va = 16'(i * 37 - 150); vb = 16'(80 - i * 11); vc = 16'(i * 5);
            if (gate_vld) pulses++;
            @(negedge clk);
        end
        sample_stb = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (gate_vld) pulses++;
            @(negedge clk);
        end
        check_eq("R6 held strobe result count", pulses, 3);

        // Mixed patterns checked against the model every cycle
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            ts = 16'($urandom_range(30000, 100));
            kr = 16'($urandom_range(2000, 0));
            va = 16'($urandom_range(65535, 0));
            vb = 16'($urandom_range(65535, 0));
            vc = 16'($urandom_range(65535, 0));
            sample_stb = 1'b1;
            @(negedge clk);
            sample_stb = 1'b0;
            repeat ($urandom_range(5, 2)) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        report();
    end
endmodule